// File: doc/BRIEF.md
# Paged Display RAM Controller

This block is the pixel memory of a monochrome panel with 65 rows and 132 columns. A host addresses it one byte at a time, by page and column. A single host byte is laid out vertically: its eight bits cover eight consecutive display rows of one column. Rows 0 to 63 form pages 0 to 7. A ninth page holds only the last row, the icon line, and stores only bit 0 of each byte. Page numbers above 8 reach no storage.

The host side works through strobes. One strobe loads the 4-bit page register, one loads the 8-bit column register, one writes a byte and one reads a byte. A second port is used by the line latch and is independent of the host. It takes a row index and returns the whole 132-bit row one cycle later. Both ports may work in the same cycle. A display read then sees the contents from before that cycle's host write.

Top module: `paged_disp_ram`

## Requirements
- R1: After reset, every stored pixel, the page register and the column register are zero. Both read outputs are also zero.
- R2: A write with page p in 0..7 and column c below 132 stores byte bit k into row 8*p+k at column c, for k from 0 to 7. All other pixels stay unchanged.
- R3: The page register is 4 bits wide and changes only in the cycle after a set-page strobe. The column register changes only after a set-column strobe. A write in the same cycle as a set strobe uses the old register values.
- R4: On page 8, a write stores only byte bit 0, into row 64 at column c. A read from page 8 returns that pixel in bit 0 and zero in bits 7 to 1.
- R5: With a page register value of 9 to 15, a write changes no pixel and a read returns 0x00.
- R6: With a column register value of 132 or more, a write changes no pixel and a read returns 0x00.
- R7: A host read strobe makes the addressed byte appear on the host read output one cycle later. Bit k of that byte is row 8*p+k. Without a strobe, the output holds its value.
- R8: A display read strobe with a row index r from 0 to 64 makes row r appear one cycle later, with output bit c equal to column c. An index above 64 returns all zeros. Without a strobe, the output holds its value.
- R9: When a host write falls in the same cycle as a display read of an affected row, or as a host read of the same byte, the read returns the contents from before the write. A later read returns the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| set_page | input | 1 | Loads the page register from page_in |
| page_in | input | 4 | New page number |
| set_col | input | 1 | Loads the column register from col_in |
| col_in | input | 8 | New column number |
| host_we | input | 1 | Writes host_wdata at the current page and column |
| host_wdata | input | 8 | Byte to write; bit k goes to the k-th row of the page |
| host_re | input | 1 | Reads the byte at the current page and column |
| host_rdata | output | 8 | Registered byte from the last host read |
| disp_re | input | 1 | Requests one display row |
| disp_row | input | 7 | Row index, 0 to 64 |
| disp_data | output | 132 | Registered row from the last display request; bit c is column c |

## Verification
A host write can fall in the same cycle as a display row read, and also in the same cycle as a host read. The random phase issues all three strobes independently. Its addresses often land on the rows that the write touches.

A bench model of the memory produces the expected read values from the contents before that cycle's write. The model is updated only after those values are fixed. A directed case then repeats a write and a display read of the same row in one cycle, and reads that row again in the next cycle to confirm the new contents.

// File: rtl/pdr_pkg.sv
package pdr_pkg;
  localparam int unsigned LINES_PER_PAGE = 8;

  // Row hit by host bit k on page p
  function automatic int unsigned row_of(input int unsigned p, input int unsigned k);
    return p * LINES_PER_PAGE + k;
  endfunction

  // True when page/column select real storage
  function automatic logic addr_in_range(input int unsigned p, input int unsigned c,
                                         input int unsigned pages, input int unsigned cols);
    return (p < pages) && (c < cols);
  endfunction
endpackage

// File: rtl/pdr_addr_regs.sv
module pdr_addr_regs #(
  parameter int unsigned PAGE_W = 4,
  parameter int unsigned COL_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_page,
  input  logic [PAGE_W-1:0] page_in,
  input  logic              set_col,
  input  logic [COL_W-1:0]  col_in,
  output logic [PAGE_W-1:0] page_q,
  output logic [COL_W-1:0]  col_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_q <= '0;
      col_q  <= '0;
    end else begin
      if (set_page) page_q <= page_in;
      if (set_col)  col_q  <= col_in;
    end
  end

  assert_page_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !set_page |=> $stable(page_q));
  assert_col_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !set_col |=> $stable(col_q));
endmodule

// File: rtl/pdr_row_store.sv
module pdr_row_store #(
  parameter int unsigned COLS   = 132,
  parameter int unsigned PAGES  = 9,
  parameter int unsigned PAGE_W = 4,
  parameter int unsigned COL_W  = 8,
  parameter int unsigned ROW_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PAGE_W-1:0] page,
  input  logic [COL_W-1:0]  col,
  input  logic              wr_hit,
  input  logic [7:0]        wdata,
  input  logic              host_re,
  input  logic              addr_ok,
  output logic [7:0]        host_rdata,
  input  logic              disp_re,
  input  logic [ROW_W-1:0]  disp_row,
  output logic [COLS-1:0]   disp_data
);
  import pdr_pkg::*;
  localparam int unsigned ROWS = (PAGES - 1) * LINES_PER_PAGE + 1;

  logic [COLS-1:0] mem [ROWS];

  // One write port per row: row r belongs to page r/8 and takes byte bit r%8
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    localparam int unsigned RP = r / LINES_PER_PAGE;
    localparam int unsigned RB = r % LINES_PER_PAGE;
    always_ff @(posedge clk) begin
      if (!rst_n) mem[r] <= '0;
      else if (wr_hit && (32'(page) == RP)) mem[r][col] <= wdata[RB];
    end
  end

  // Host byte gather, from the contents before this cycle's write
  logic [7:0] gather;
  always_comb begin
    gather = '0;
    if (addr_ok) begin
      for (int k = 0; k < LINES_PER_PAGE; k++) begin
        if (row_of(32'(page), k) < ROWS) gather[k] = mem[row_of(32'(page), k)][col];
      end
    end
  end

  logic row_ok;
  assign row_ok = 32'(disp_row) < ROWS;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      host_rdata <= '0;
      disp_data  <= '0;
    end else begin
      if (host_re) host_rdata <= gather;
      if (disp_re) disp_data  <= row_ok ? mem[disp_row] : '0;
    end
  end

  assert_icon_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    host_re && (32'(page) == PAGES - 1) |=> host_rdata[7:1] == '0);
  assert_bad_page_reads_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    host_re && (32'(page) >= PAGES) |=> host_rdata == '0);
  assert_bad_col_reads_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    host_re && (32'(col) >= COLS) |=> host_rdata == '0);
  assert_host_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !host_re |=> $stable(host_rdata));
  assert_bad_row_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    disp_re && !row_ok |=> disp_data == '0);
  assert_disp_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_re |=> $stable(disp_data));
endmodule

// File: rtl/paged_disp_ram.sv
module paged_disp_ram #(
  parameter int unsigned COLS   = 132,
  parameter int unsigned PAGES  = 9,
  parameter int unsigned PAGE_W = 4,
  parameter int unsigned COL_W  = 8,
  parameter int unsigned ROW_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_page,
  input  logic [PAGE_W-1:0] page_in,
  input  logic              set_col,
  input  logic [COL_W-1:0]  col_in,
  input  logic              host_we,
  input  logic [7:0]        host_wdata,
  input  logic              host_re,
  output logic [7:0]        host_rdata,
  input  logic              disp_re,
  input  logic [ROW_W-1:0]  disp_row,
  output logic [COLS-1:0]   disp_data
);
  import pdr_pkg::*;

  logic [PAGE_W-1:0] page_q;
  logic [COL_W-1:0]  col_q;
  logic              addr_ok;
  logic              wr_hit;

  pdr_addr_regs #(.PAGE_W(PAGE_W), .COL_W(COL_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .set_page(set_page), .page_in(page_in),
    .set_col(set_col), .col_in(col_in),
    .page_q(page_q), .col_q(col_q)
  );

  assign addr_ok = addr_in_range(32'(page_q), 32'(col_q), PAGES, COLS);
  assign wr_hit  = host_we && addr_ok;

  pdr_row_store #(.COLS(COLS), .PAGES(PAGES), .PAGE_W(PAGE_W),
                  .COL_W(COL_W), .ROW_W(ROW_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .page(page_q), .col(col_q),
    .wr_hit(wr_hit), .wdata(host_wdata),
    .host_re(host_re), .addr_ok(addr_ok), .host_rdata(host_rdata),
    .disp_re(disp_re), .disp_row(disp_row), .disp_data(disp_data)
  );

  assert_no_stray_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |-> (32'(page_q) < PAGES) && (32'(col_q) < COLS));
endmodule

// File: tb/tb_paged_disp_ram.sv
module tb_paged_disp_ram;
  logic         clk = 0, rst_n = 0;
  logic         set_page = 0, set_col = 0, host_we = 0, host_re = 0, disp_re = 0;
  logic [3:0]   page_in = 0;
  logic [7:0]   col_in = 0, host_wdata = 0;
  logic [6:0]   disp_row = 0;
  logic [7:0]   host_rdata;
  logic [131:0] disp_data;

  int checks = 0, fails = 0;
  bit [131:0] model [65];
  int cur_page = 0, cur_col = 0;

  paged_disp_ram dut (.*);

  always #10 clk = ~clk;

  // Expected byte: bit k is row 8*page+k, icon page keeps bit 0 only
  function automatic bit [7:0] exp_byte(int p, int c);
    bit [7:0] b = 0;
    if (p > 8 || c > 131) return 0;
    if (p == 8) begin b[0] = model[64][c]; return b; end
    for (int k = 0; k < 8; k++) b[k] = model[p*8+k][c];
    return b;
  endfunction

  function automatic bit [131:0] exp_row(int r);
    return (r > 64) ? '0 : model[r];
  endfunction

  task automatic model_write(int p, int c, bit [7:0] d);
    if (p > 8 || c > 131) return;
    if (p == 8) model[64][c] = d[0];
    else for (int k = 0; k < 8; k++) model[p*8+k][c] = d[k];
  endtask

  task automatic chk8(string req, bit [7:0] act, bit [7:0] exp);
    checks++;
    if (act !== exp) begin fails++; $display("FAIL %s actual=%h expected=%h", req, act, exp); end
  endtask

  task automatic chkrow(string req, bit [131:0] act, bit [131:0] exp);
    checks++;
    if (act !== exp) begin fails++; $display("FAIL %s actual=%h expected=%h", req, act, exp); end
  endtask

  // One cycle: drive at negedge, sample at the following negedge
  task automatic cyc(bit sp, int p, bit sc, int c, bit we, bit [7:0] d,
                     bit re, bit dre, int r, output bit [7:0] eb, output bit [131:0] er);
    set_page = sp; page_in = 4'(p); set_col = sc; col_in = 8'(c);
    host_we = we; host_wdata = d; host_re = re; disp_re = dre; disp_row = 7'(r);
    eb = re  ? exp_byte(cur_page, cur_col) : host_rdata;
    er = dre ? exp_row(r) : disp_data;
    if (we) model_write(cur_page, cur_col, d);
    @(negedge clk);
    if (sp) cur_page = p;
    if (sc) cur_col = c;
    set_page = 0; set_col = 0; host_we = 0; host_re = 0; disp_re = 0;
  endtask

  task automatic setaddr(int p, int c);
    bit [7:0] eb; bit [131:0] er;
    cyc(1, p, 1, c, 0, 0, 0, 0, 0, eb, er);
  endtask
  task automatic wr(int p, int c, bit [7:0] d);
    bit [7:0] eb; bit [131:0] er;
    setaddr(p, c); cyc(0, 0, 0, 0, 1, d, 0, 0, 0, eb, er);
  endtask
  task automatic rd(string req, int p, int c);
    bit [7:0] eb; bit [131:0] er;
    setaddr(p, c); cyc(0, 0, 0, 0, 0, 0, 1, 0, 0, eb, er);
    chk8(req, host_rdata, eb);
  endtask
  task automatic drow(string req, int r);
    bit [7:0] eb; bit [131:0] er;
    cyc(0, 0, 0, 0, 0, 0, 0, 1, r, eb, er);
    chkrow(req, disp_data, er);
  endtask

  initial begin
    #4_000_000;
    fails++; $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    bit [7:0] eb; bit [131:0] er;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk8("R1 reset host", host_rdata, 0);
    chkrow("R1 reset disp", disp_data, 0);
    drow("R1 row0", 0); drow("R1 row64", 64); rd("R1 byte", 3, 77);

    wr(2, 5, 8'hA5); rd("R2 R7 page2", 2, 5); drow("R2 row16", 16); drow("R2 row23", 23);
    wr(7, 131, 8'h81); drow("R2 row63", 63); drow("R2 row56", 56);
    wr(0, 0, 8'hFF); rd("R2 page0 col0", 0, 0);

    wr(8, 10, 8'hFE); rd("R4 icon bit0 clear", 8, 10); drow("R4 row64 a", 64);
    wr(8, 11, 8'hFF); rd("R4 icon upper zero", 8, 11); drow("R4 row64 b", 64);

    wr(9, 4, 8'hFF); wr(15, 4, 8'hFF); rd("R5 page9 read", 9, 4); rd("R5 page15 read", 15, 4);
    drow("R5 rows unchanged", 32);
    wr(3, 132, 8'hFF); wr(3, 255, 8'hFF); rd("R6 col132 read", 3, 132);
    drow("R6 row24", 24); drow("R6 row31", 31);

    // R3: set-page with write same cycle uses old page
    setaddr(1, 40);
    cyc(1, 4, 0, 0, 1, 8'h3C, 0, 0, 0, eb, er);
    rd("R3 old page written", 1, 40); rd("R3 new page untouched", 4, 40);
    setaddr(6, 6);
    cyc(0, 0, 0, 0, 0, 0, 1, 0, 0, eb, er);
    page_in = 4'd2; @(negedge clk);
    cyc(0, 0, 0, 0, 0, 0, 1, 0, 0, eb, er); chk8("R3 page held", host_rdata, eb);

    // R7/R8 hold without strobe
    drow("R8 pre", 16);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 3, eb, er);
    chkrow("R8 hold", disp_data, er); chk8("R7 hold", host_rdata, eb);
    drow("R8 row 100 zero", 100);

    // R9 same-cycle write and display read / host read
    setaddr(5, 50);
    cyc(0, 0, 0, 0, 1, 8'hFF, 1, 1, 40, eb, er);
    chk8("R9 host old", host_rdata, eb); chkrow("R9 disp old", disp_data, er);
    drow("R9 disp new", 40); rd("R9 host new", 5, 50);

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      bit sp = ($urandom % 4) == 0, sc = ($urandom % 3) == 0;
      int p = ($urandom % 8 == 0) ? ($urandom % 16) : ($urandom % 9);
      int c = ($urandom % 10 == 0) ? ($urandom % 256) : ($urandom % 132);
      bit we = $urandom % 2, re = $urandom % 2, dre = $urandom % 2;
      int r = ($urandom % 2) ? cur_page * 8 + ($urandom % 8) : ($urandom % 70);
      cyc(sp, p, sc, c, we, 8'($urandom), re, dre, r, eb, er);
      chk8("R7 R9 random host", host_rdata, eb);
      chkrow("R8 R9 random disp", disp_data, er);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule